// File: doc/BRIEF.md
# Maskable Data Watchpoint Comparator

This block is one watchpoint comparator for a processor debug subsystem. It watches the bus accesses of a core and raises flags when a programmed value matches. Each access arrives on a simple strobe that carries the instruction address, the data address and the data value. A free-running cycle count is also presented every clock. A small write-only register port sets three things: the compare value, a mask width, and a function word. The function word picks the quantity that is compared and the outputs that fire.

On a match, the block gives three outputs, each one clock after the access. It drives a one-cycle compare-match pulse. It can raise a debug event that carries either the program counter or the data address. It can also emit a trace record holding the fields chosen in the function word. The trace record leaves on a valid/ready handshake. A record that is waiting is never overwritten; a match that finds the slot busy sets a sticky overflow flag instead.

Top module: `wp_comparator`

## Requirements
- R1: After reset, cmp_match, dbg_event, tr_valid and tr_overflow are low, and the comparator is disabled (function source code 0).
- R2: Register writes use cfg_sel: 0 writes the compare value, 1 writes the mask width (cfg_wdata[3:0]), and 2 writes the function word. Function word fields are: [2:0] source (0 off, 1 data address, 2 instruction address, 3 data value, 4 cycle count), [3] trace PC, [4] trace data-address low half, [5] trace data value, [6] event enable, [7] event reports data address (else PC). A write takes effect for accesses in the next cycle.
- R3: In data-address mode, a valid access matches when acc_daddr equals the compare value in all bits except the lowest N bits. N is the mask width, from 0 to 15.
- R4: In instruction-address mode, acc_pc is compared under the same mask rule as R3.
- R5: In data-value mode, acc_dval must equal the compare value in every bit; the mask is ignored.
- R6: Cycle-count mode compares cyc_count with the compare value every clock, without needing acc_valid, only when the parameter CMP_INDEX is 0. An instance with any other index never matches in that mode.
- R7: Each qualifying match drives cmp_match high for exactly the one cycle after that access. With source code 0, no output fires.
- R8: With event enable set, a match drives dbg_event in the same cycle as cmp_match. dbg_event_addr then carries acc_daddr if bit 7 is set, or acc_pc otherwise.
- R9: On a match, a trace record is produced when at least one trace field is enabled, and not otherwise. In the record, tr_fields bit 0 marks the PC, bit 1 marks the data-address low 16 bits, and bit 2 marks the data value. Each field that is not enabled reads as zero.
- R10: While tr_valid is high and tr_ready is low, the record stays unchanged. A match in that state sets tr_overflow. The flag stays set until the next function-word write.
- R11: In address and value modes, cycles with acc_valid low never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 value, 1 mask, 2 function) |
| cfg_wdata | input | W | Register write data |
| acc_valid | input | 1 | Access strobe |
| acc_pc | input | W | Instruction address of the access |
| acc_daddr | input | W | Data address of the access |
| acc_dval | input | W | Data value of the access |
| cyc_count | input | W | Free-running cycle count |
| cmp_match | output | 1 | One-cycle match pulse |
| dbg_event | output | 1 | Watchpoint debug event |
| dbg_event_addr | output | W | Address reported with the event |
| tr_valid | output | 1 | Trace record valid |
| tr_ready | input | 1 | Trace record accepted |
| tr_pc | output | W | Record: instruction address |
| tr_daddr_lo | output | 16 | Record: low half of data address |
| tr_dval | output | W | Record: data value |
| tr_fields | output | 3 | Record: which fields are present |
| tr_overflow | output | 1 | Sticky lost-record flag |

## Verification
The hardest case to reach from the ports is a match that arrives while an earlier trace record is still stalled. To reach it, the bench holds tr_ready low. It then fires two matching accesses back to back, with different program counters. The record from the first access must survive intact, and only the overflow flag may change. The bench then releases ready and writes the function word, and checks that the slot drains and the flag clears. A second instance with a nonzero index shares every input, so cycle-count mode is checked on both instances in the same cycles.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [2:0] {
        SRC_OFF   = 3'd0,
        SRC_DADDR = 3'd1,
        SRC_IADDR = 3'd2,
        SRC_DVAL  = 3'd3,
        SRC_CYC   = 3'd4
    } wp_src_e;

    typedef struct packed {
        logic    ev_on_daddr;
        logic    ev_en;
        logic    tr_val;
        logic    tr_off;
        logic    tr_pc;
        wp_src_e src;
    } wp_func_t;

    localparam int FUNC_W   = 8;
    localparam int SEL_COMP = 0;
    localparam int SEL_MASK = 1;
    localparam int SEL_FUNC = 2;
endpackage

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs
    import wp_pkg::*;
#(
    parameter int W      = 32,
    parameter int MASK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [W-1:0]      cfg_wdata,
    output logic [W-1:0]      comp,
    output logic [MASK_W-1:0] mask,
    output wp_func_t          func,
    output logic              func_wr
);
    typedef struct packed {
        logic [W-1:0]      comp;
        logic [MASK_W-1:0] mask;
        wp_func_t          func;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        func_wr = 1'b0;
        if (cfg_we) begin
            case (int'(cfg_sel))
                SEL_COMP: st_d.comp = cfg_wdata;
                SEL_MASK: st_d.mask = cfg_wdata[MASK_W-1:0];
                SEL_FUNC: begin
                    st_d.func.src         = wp_src_e'(cfg_wdata[2:0]);
                    st_d.func.tr_pc       = cfg_wdata[3];
                    st_d.func.tr_off      = cfg_wdata[4];
                    st_d.func.tr_val      = cfg_wdata[5];
                    st_d.func.ev_en       = cfg_wdata[6];
                    st_d.func.ev_on_daddr = cfg_wdata[7];
                    func_wr               = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign comp = st_q.comp;
    assign mask = st_q.mask;
    assign func = st_q.func;
endmodule

// File: rtl/wp_match.sv
module wp_match
    import wp_pkg::*;
#(
    parameter int W         = 32,
    parameter int MASK_W    = 4,
    parameter int CMP_INDEX = 0
) (
    input  wp_src_e           src,
    input  logic [W-1:0]      comp,
    input  logic [MASK_W-1:0] mask,
    input  logic              acc_valid,
    input  logic [W-1:0]      acc_pc,
    input  logic [W-1:0]      acc_daddr,
    input  logic [W-1:0]      acc_dval,
    input  logic [W-1:0]      cyc_count,
    output logic              hit
);
    logic         cyc_ok;
    logic [W-1:0] operand;
    logic [W-1:0] keep;
    logic         qual;

    generate
        if (CMP_INDEX == 0) begin : g_cyc_on
            assign cyc_ok = 1'b1;
        end else begin : g_cyc_off
            assign cyc_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        operand = '0;
        keep    = '1;
        qual    = 1'b0;
        unique case (src)
            SRC_DADDR: begin
                operand = acc_daddr;
                keep    = {W{1'b1}} << mask;
                qual    = acc_valid;
            end
            SRC_IADDR: begin
                operand = acc_pc;
                keep    = {W{1'b1}} << mask;
                qual    = acc_valid;
            end
            SRC_DVAL: begin
                operand = acc_dval;
                qual    = acc_valid;
            end
            SRC_CYC: begin
                operand = cyc_count;
                qual    = cyc_ok;
            end
            default: ;
        endcase
        hit = qual && (((operand ^ comp) & keep) == '0);
    end

    always_comb begin
        // R6
        if (CMP_INDEX != 0 && src == SRC_CYC) begin
            cyc_index_chk: assert (!hit);
        end
    end
endmodule

// File: rtl/wp_trace_buf.sv
module wp_trace_buf #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] in_pc,
    input  logic [15:0]  in_off,
    input  logic [W-1:0] in_val,
    input  logic [2:0]   in_fields,
    input  logic         clr_ovf,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] out_pc,
    output logic [15:0]  out_off,
    output logic [W-1:0] out_val,
    output logic [2:0]   out_fields,
    output logic         ovf
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] pc;
        logic [15:0]  off;
        logic [W-1:0] val;
        logic [2:0]   fields;
        logic         ovf;
    } tb_t;

    tb_t st_d, st_q;
    logic blocked;

    always_comb begin
        st_d    = st_q;
        blocked = st_q.valid && !ready;
        if (!blocked) begin
            st_d.valid = load;
            if (load) begin
                st_d.pc     = in_pc;
                st_d.off    = in_off;
                st_d.val    = in_val;
                st_d.fields = in_fields;
            end
        end
        if (clr_ovf) begin
            st_d.ovf = 1'b0;
        end else if (blocked && load) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid      = st_q.valid;
    assign out_pc     = st_q.pc;
    assign out_off    = st_q.off;
    assign out_val    = st_q.val;
    assign out_fields = st_q.fields;
    assign ovf        = st_q.ovf;

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(out_pc) && $stable(out_off)
                               && $stable(out_val) && $stable(out_fields)));

    // R10
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(valid && !ready));
endmodule

// File: rtl/wp_comparator.sv
module wp_comparator
    import wp_pkg::*;
#(
    parameter int W         = 32,
    parameter int MASK_W    = 4,
    parameter int CMP_INDEX = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_sel,
    input  logic [W-1:0] cfg_wdata,
    input  logic         acc_valid,
    input  logic [W-1:0] acc_pc,
    input  logic [W-1:0] acc_daddr,
    input  logic [W-1:0] acc_dval,
    input  logic [W-1:0] cyc_count,
    output logic         cmp_match,
    output logic         dbg_event,
    output logic [W-1:0] dbg_event_addr,
    output logic         tr_valid,
    input  logic         tr_ready,
    output logic [W-1:0] tr_pc,
    output logic [15:0]  tr_daddr_lo,
    output logic [W-1:0] tr_dval,
    output logic [2:0]   tr_fields,
    output logic         tr_overflow
);
    localparam int OFF_W = 16;

    logic [W-1:0]      comp;
    logic [MASK_W-1:0] mask;
    wp_func_t          func;
    logic              func_wr;
    logic              hit;

    wp_cfg_regs #(.W(W), .MASK_W(MASK_W)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .comp      (comp),
        .mask      (mask),
        .func      (func),
        .func_wr   (func_wr)
    );

    wp_match #(.W(W), .MASK_W(MASK_W), .CMP_INDEX(CMP_INDEX)) i_match (
        .src       (func.src),
        .comp      (comp),
        .mask      (mask),
        .acc_valid (acc_valid),
        .acc_pc    (acc_pc),
        .acc_daddr (acc_daddr),
        .acc_dval  (acc_dval),
        .cyc_count (cyc_count),
        .hit       (hit)
    );

    typedef struct packed {
        logic         match;
        logic         ev;
        logic [W-1:0] ev_addr;
    } out_t;

    out_t st_d, st_q;
    logic            tr_load;
    logic [W-1:0]    rec_pc;
    logic [OFF_W-1:0] rec_off;
    logic [W-1:0]    rec_val;
    logic [2:0]      rec_fields;

    always_comb begin
        st_d       = st_q;
        st_d.match = hit;
        st_d.ev    = hit && func.ev_en;
        if (hit && func.ev_en) begin
            st_d.ev_addr = func.ev_on_daddr ? acc_daddr : acc_pc;
        end
        rec_fields = {func.tr_val, func.tr_off, func.tr_pc};
        rec_pc     = func.tr_pc  ? acc_pc : '0;
        rec_off    = func.tr_off ? acc_daddr[OFF_W-1:0] : '0;
        rec_val    = func.tr_val ? acc_dval : '0;
        tr_load    = hit && (rec_fields != 3'b000);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    wp_trace_buf #(.W(W)) i_trace (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tr_load),
        .in_pc      (rec_pc),
        .in_off     (rec_off),
        .in_val     (rec_val),
        .in_fields  (rec_fields),
        .clr_ovf    (func_wr),
        .ready      (tr_ready),
        .valid      (tr_valid),
        .out_pc     (tr_pc),
        .out_off    (tr_daddr_lo),
        .out_val    (tr_dval),
        .out_fields (tr_fields),
        .ovf        (tr_overflow)
    );

    assign cmp_match      = st_q.match;
    assign dbg_event      = st_q.ev;
    assign dbg_event_addr = st_q.ev_addr;

    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_match |-> ($past(func.src) != SRC_OFF));

    // R8
    event_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_event |-> cmp_match);

    // R11
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_match && ($past(func.src) != SRC_CYC)) |-> $past(acc_valid));

    // R9
    record_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tr_valid) |-> cmp_match);
endmodule

// File: tb/test_wp_comparator.sv
module test_wp_comparator;
    localparam int W = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n, cfg_we, acc_valid, tr_ready;
    logic [1:0]   cfg_sel;
    logic [W-1:0] cfg_wdata, acc_pc, acc_daddr, acc_dval, cyc_count;
    logic         m0, ev0, tv0, ovf0, m1, ev1, tv1, ovf1;
    logic [W-1:0] ea0, tpc0, tval0, ea1, tpc1, tval1;
    logic [15:0]  toff0, toff1;
    logic [2:0]   tf0, tf1;

    wp_comparator #(.W(W), .CMP_INDEX(0)) i_wp_comparator (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_daddr(acc_daddr), .acc_dval(acc_dval),
        .cyc_count(cyc_count), .cmp_match(m0), .dbg_event(ev0), .dbg_event_addr(ea0),
        .tr_valid(tv0), .tr_ready(tr_ready), .tr_pc(tpc0), .tr_daddr_lo(toff0),
        .tr_dval(tval0), .tr_fields(tf0), .tr_overflow(ovf0));

    wp_comparator #(.W(W), .CMP_INDEX(1)) i_wp_comparator_b (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_daddr(acc_daddr), .acc_dval(acc_dval),
        .cyc_count(cyc_count), .cmp_match(m1), .dbg_event(ev1), .dbg_event_addr(ea1),
        .tr_valid(tv1), .tr_ready(tr_ready), .tr_pc(tpc1), .tr_daddr_lo(toff1),
        .tr_dval(tval1), .tr_fields(tf1), .tr_overflow(ovf1));

    typedef struct {
        string        tag;
        logic         m0, m1, ev;
        logic [W-1:0] ea;
        logic         tv;
        logic [W-1:0] tpc;
        logic [15:0]  toff;
        logic [W-1:0] tval;
        logic [2:0]   tf;
    } exp_t;

    exp_t q[$];
    int n_tests = 0;
    int n_fail  = 0;

    logic [W-1:0] m_comp = '0;
    logic [3:0]   m_mask = '0;
    logic [7:0]   m_func = '0;
    localparam logic [W-1:0] IDLE_CYC = 32'hDEAD_0000;

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic model_hit(int idx, logic v, logic [W-1:0] pc, da, dv, cy);
        logic [W-1:0] keep;
        keep = {W{1'b1}} << m_mask;
        case (m_func[2:0])
            3'd1: return v && ((da & keep) == (m_comp & keep));
            3'd2: return v && ((pc & keep) == (m_comp & keep));
            3'd3: return v && (dv == m_comp);
            3'd4: return (idx == 0) && (cy == m_comp);
            default: return 1'b0;
        endcase
    endfunction

    task automatic idle();
        acc_valid = 1'b0;
        cyc_count = IDLE_CYC;
    endtask

    task automatic wr(int sel, logic [W-1:0] data);
        @(negedge clk);
        idle();
        cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = data;
        @(posedge clk);
        #1 cfg_we = 1'b0;
        case (sel)
            0: m_comp = data;
            1: m_mask = data[3:0];
            default: m_func = data[7:0];
        endcase
    endtask

    task automatic acc(string tag, logic v, logic [W-1:0] pc, da, dv, cy, bit push = 1);
        exp_t e;
        logic h;
        @(negedge clk);
        acc_valid = v; acc_pc = pc; acc_daddr = da; acc_dval = dv; cyc_count = cy;
        h      = model_hit(0, v, pc, da, dv, cy);
        e.tag  = tag;
        e.m0   = h;
        e.m1   = model_hit(1, v, pc, da, dv, cy);
        e.ev   = h && m_func[6];
        e.ea   = m_func[7] ? da : pc;
        e.tv   = h && (m_func[5:3] != 3'b000);
        e.tpc  = m_func[3] ? pc : '0;
        e.toff = m_func[4] ? da[15:0] : '0;
        e.tval = m_func[5] ? dv : '0;
        e.tf   = m_func[5:3];
        @(posedge clk);
        if (push) q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " match"}, W'(m0), W'(e.m0));
            chk({e.tag, " match idx1"}, W'(m1), W'(e.m1));
            chk({e.tag, " event"}, W'(ev0), W'(e.ev));
            if (e.ev) chk({e.tag, " event addr"}, ea0, e.ea);
            chk({e.tag, " trace valid"}, W'(tv0), W'(e.tv));
            if (e.tv) begin
                chk({e.tag, " trace pc"}, tpc0, e.tpc);
                chk({e.tag, " trace off"}, W'(toff0), W'(e.toff));
                chk({e.tag, " trace val"}, tval0, e.tval);
                chk({e.tag, " trace fields"}, W'(tf0), W'(e.tf));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; tr_ready = 1'b1;
        acc_pc = '0; acc_daddr = '0; acc_dval = '0;
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 match", W'(m0), 0);
        chk("R1 event", W'(ev0), 0);
        chk("R1 trace valid", W'(tv0), 0);
        chk("R1 overflow", W'(ovf0), 0);
        acc("R1/R7 off mode", 1, 32'h0, 32'h0, 32'h0, 32'h0);

        // R2 R3 data address with mask, event on data address, all trace fields
        wr(0, 32'h0000_1000);
        wr(1, 4);
        wr(2, 32'hF9);
        acc("R3 in range", 1, 32'h100, 32'h0000_100F, 32'h55, IDLE_CYC);
        acc("R3 above range", 1, 32'h104, 32'h0000_1010, 32'h56, IDLE_CYC);
        acc("R11 no strobe", 0, 32'h108, 32'h0000_1000, 32'h57, IDLE_CYC);
        acc("R7 back-to-back", 1, 32'h10C, 32'h0000_1003, 32'h58, IDLE_CYC);
        acc("R7 second", 1, 32'h110, 32'h0000_1004, 32'h59, IDLE_CYC);
        wr(1, 0);
        acc("R3 mask0 exact", 1, 32'h114, 32'h0000_1000, 32'h5A, IDLE_CYC);
        acc("R3 mask0 off by one", 1, 32'h118, 32'h0000_1001, 32'h5B, IDLE_CYC);
        wr(1, 15);
        acc("R3 mask15 low", 1, 32'h11C, 32'h0000_7FFF, 32'h5C, IDLE_CYC);
        acc("R3 mask15 out", 1, 32'h120, 32'h0000_8000, 32'h5D, IDLE_CYC);

        // R4 instruction address, event on PC, trace PC only
        wr(1, 2);
        wr(0, 32'h0800_0040);
        wr(2, 32'h4A);
        acc("R4 pc hit", 1, 32'h0800_0043, 32'h2000_0000, 32'h1, IDLE_CYC);
        acc("R4 pc miss", 1, 32'h0800_0044, 32'h0800_0040, 32'h2, IDLE_CYC);

        // R5 data value, mask ignored, no trace fields, no event
        wr(0, 32'hCAFE_0000);
        wr(2, 32'h03);
        acc("R5 value hit", 1, 32'h1, 32'h2, 32'hCAFE_0000, IDLE_CYC);
        acc("R5 mask not applied", 1, 32'h1, 32'h2, 32'hCAFE_0001, IDLE_CYC);
        // R9 value-only trace
        wr(2, 32'h23);
        acc("R9 value field", 1, 32'h77, 32'h0000_ABCD, 32'hCAFE_0000, IDLE_CYC);

        // R6 cycle count on both indices
        wr(0, 32'h0000_0500);
        wr(2, 32'h54);
        acc("R6 cycle hit", 0, 32'h300, 32'h0001_2345, 32'h0, 32'h0000_0500);
        acc("R6 cycle miss", 0, 32'h300, 32'h0001_2345, 32'h0, 32'h0000_0501);

        // R7 disabled with matching value
        wr(2, 32'hF8);
        acc("R7 off", 1, 32'h500, 32'h500, 32'h500, 32'h0000_0500);

        // R10 back-pressure
        wr(0, 32'h0000_2000);
        wr(1, 0);
        wr(2, 32'h09);
        @(negedge clk); tr_ready = 1'b0;
        acc("R10 first", 1, 32'hA1, 32'h0000_2000, 32'h0, IDLE_CYC, 0);
        @(negedge clk); idle();
        chk("R10 valid held", W'(tv0), 1);
        chk("R10 first pc", tpc0, 32'hA1);
        chk("R10 no overflow yet", W'(ovf0), 0);
        acc("R10 second", 1, 32'hA2, 32'h0000_2000, 32'h0, IDLE_CYC, 0);
        @(negedge clk); idle();
        chk("R10 record kept", tpc0, 32'hA1);
        chk("R10 overflow set", W'(ovf0), 1);
        tr_ready = 1'b1;
        @(negedge clk);
        chk("R10 drained", W'(tv0), 0);
        chk("R10 overflow sticky", W'(ovf0), 1);
        wr(2, 32'h09);
        @(negedge clk);
        chk("R10 overflow cleared", W'(ovf0), 0);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule